// File: doc/BRIEF.md
# Scaler Pool Allocator

A small pool of image scalers is shared among several users: the planes of a display pipe and one pipe-level user, which always sits at the highest user index. Each user stages a request through a single update port. The port carries the user index, the source and destination sizes, a semiplanar 4:2:0 flag, an explicit need flag, a release flag and the interlaced flag of the output timing. A staged request either sets the user's request bit, releases the user, or is rejected with a one-cycle error pulse.

A commit strobe first runs an admission check: it counts the set request bits and compares the count with the pool size. If the commit is admitted, the block walks the user slots one per clock, from lowest to highest. Each requesting user that holds no scaler receives the lowest-numbered free one. Each scaler gets an operating mode: normal, dynamic or high-quality. A lone user on a pool of two or more scalers is moved onto scaler 0, which then runs in high-quality mode. At the end of the walk, the block pulses `done_o` together with a mask of the scalers left unused. Downstream logic uses that mask to clear the control words of those scalers.

Top module: `scl_pool_alloc`

## Requirements
- R1: A staged user needs a scaler when its source width differs from its destination width, when its source height differs from its destination height, or when `need_i` is set. A staged user with no need sets no request bit and raises no error.
- R2: Releasing a user clears its request bit, frees the scaler it held and shows its `assign_o` field as none (all ones, 2'b11 at default widths) in the next cycle. A release is either `release_i` or a staging with no need.
- R3: A needing request is rejected when any of the four sizes is below MIN_DIM (8) or above MAX_DIM (4096). A rejected request pulses `err_o` for one cycle and leaves the request mask unchanged. Both bounds themselves are accepted.
- R4: For users other than the pipe user (index NUM_USERS-1), a needing request with `semiplanar_i` set is rejected when the source width or height is below MIN_SEMI_DIM (16). The pipe user ignores `semiplanar_i`.
- R5: A needing request with `interlaced_i` set is rejected. A staging with no need is accepted whatever `interlaced_i` is.
- R6: A commit is rejected when the number of set request bits exceeds NUM_SCALERS. A rejected commit raises `err_o` and `done_o` in the cycle after the accepting edge and changes no assignment. A count equal to NUM_SCALERS is admitted.
- R7: The walk visits users from lowest to highest index. A requesting user without a scaler gets the lowest-numbered scaler not in use. A user that already holds a scaler keeps it. No scaler is ever held by two users.
- R8: When exactly one request bit is set and the pool has more than one scaler, the lone user ends on scaler 0 in high-quality mode. Otherwise every scaler in use runs dynamic mode. `mode_o` holds 2 bits per scaler, scaler j at bits [2j+1:2j]: 0 normal, 1 dynamic, 2 high-quality.
- R9: When the walk finishes, `detach_o` shows, for one cycle together with `done_o`, a bit set for every scaler not in use (bit j = scaler j). Each such scaler returns to normal mode.
- R10: An admitted commit sets `busy_o`, and `done_o` pulses for one cycle NUM_USERS rising edges after the accepting edge. Updates and commits presented while busy are ignored. An update presented together with a commit is also ignored.
- R11: After reset the request mask is empty, every user is assigned none, every scaler is in normal mode, and `busy_o`, `done_o`, `err_o` and `detach_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Stage a request for one user |
| upd_user_i | input | $clog2(NUM_USERS) | User index of the staged request |
| src_w_i | input | DIM_W | Source width |
| src_h_i | input | DIM_W | Source height |
| dst_w_i | input | DIM_W | Destination width |
| dst_h_i | input | DIM_W | Destination height |
| semiplanar_i | input | 1 | Source is semiplanar 4:2:0 |
| need_i | input | 1 | Scaler needed even at equal sizes |
| release_i | input | 1 | Force release of the user |
| interlaced_i | input | 1 | Output timing is interlaced |
| commit_i | input | 1 | Run admission and assignment |
| req_mask_o | output | NUM_USERS | Current request bits |
| assign_o | output | NUM_USERS*$clog2(NUM_SCALERS+1) | Scaler index per user, all ones for none |
| mode_o | output | 2*NUM_SCALERS | Mode per scaler |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Commit finished (one cycle) |
| err_o | output | 1 | Staging or admission rejected (one cycle) |
| detach_o | output | NUM_SCALERS | Unused scalers at walk end (one cycle) |

## Verification
A stale in-use flag shows up at the next commit in two ways: a new user is handed a scaler number above the lowest free one, and `detach_o` omits a scaler that has no owner. Both are visible in the single `done_o` cycle. A missed release shows one cycle after staging, as an `assign_o` field that is not all ones. A wrong popcount shows as an `err_o` that either appears or fails to appear in the first cycle after the commit. A wrong lone-user decision shows as a `mode_o` value in the `done_o` cycle that does not match the count of set request bits.

// File: rtl/scl_pkg.sv
package scl_pkg;
  timeunit 1ns; timeprecision 1ps;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_DYN    = 2'd1,
    MODE_HQ     = 2'd2
  } mode_e;
endpackage

// File: rtl/scl_req_check.sv
module scl_req_check #(
  parameter int DIM_W        = 14,
  parameter int MIN_DIM      = 8,
  parameter int MAX_DIM      = 4096,
  parameter int MIN_SEMI_DIM = 16
) (
  input  logic [DIM_W-1:0] src_w_i,
  input  logic [DIM_W-1:0] src_h_i,
  input  logic [DIM_W-1:0] dst_w_i,
  input  logic [DIM_W-1:0] dst_h_i,
  input  logic             semiplanar_i,
  input  logic             need_i,
  input  logic             release_i,
  input  logic             interlaced_i,
  input  logic             is_pipe_i,
  output logic             release_o,
  output logic             reject_o
);
  timeunit 1ns; timeprecision 1ps;
  localparam logic [DIM_W-1:0] LO   = DIM_W'(MIN_DIM);
  localparam logic [DIM_W-1:0] HI   = DIM_W'(MAX_DIM);
  localparam logic [DIM_W-1:0] SEMI = DIM_W'(MIN_SEMI_DIM);

  logic need, rng_bad, semi_bad;

  always_comb begin
    need     = need_i || (src_w_i != dst_w_i) || (src_h_i != dst_h_i);
    rng_bad  = (src_w_i < LO) || (src_h_i < LO) || (dst_w_i < LO) || (dst_h_i < LO) ||
               (src_w_i > HI) || (src_h_i > HI) || (dst_w_i > HI) || (dst_h_i > HI);
    semi_bad = semiplanar_i && !is_pipe_i && ((src_w_i < SEMI) || (src_h_i < SEMI));
    release_o = release_i || !need;
    reject_o  = !release_o && (interlaced_i || rng_bad || semi_bad);
  end
endmodule

// File: rtl/scl_popcount.sv
module scl_popcount #(
  parameter int W  = 5,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  timeunit 1ns; timeprecision 1ps;
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/scl_walk.sv
module scl_walk
  import scl_pkg::*;
#(
  parameter int NUM_USERS    = 5,
  parameter int NUM_SCALERS  = 2,
  parameter bit LEGACY_MODES = 1'b1,
  parameter int UW           = $clog2(NUM_USERS),
  parameter int IW           = $clog2(NUM_SCALERS + 1),
  parameter int CW           = $clog2(NUM_USERS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      upd_i,
  input  logic [UW-1:0]             upd_user_i,
  input  logic                      release_i,
  input  logic                      reject_i,
  input  logic                      commit_i,
  input  logic [CW-1:0]             req_cnt_i,
  output logic [NUM_USERS-1:0]      req_mask_o,
  output logic [NUM_USERS*IW-1:0]   assign_o,
  output logic [2*NUM_SCALERS-1:0]  mode_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      err_o,
  output logic [NUM_SCALERS-1:0]    detach_o
);
  timeunit 1ns; timeprecision 1ps;
  localparam logic [IW-1:0] NONE     = '1;
  localparam mode_e         SHR_MODE = LEGACY_MODES ? MODE_DYN : MODE_NORMAL;
  localparam bool_lone_ok_t = 0;

  logic [NUM_USERS-1:0]   req_q;
  logic [IW-1:0]          asg_q [NUM_USERS];
  logic [IW-1:0]          asg_n [NUM_USERS];
  logic [NUM_SCALERS-1:0] inuse_q, inuse_n, detach_q;
  mode_e                  mode_q [NUM_SCALERS];
  mode_e                  mode_n [NUM_SCALERS];
  logic                   busy_q, done_q, err_q, lone_q;
  logic [UW-1:0]          idx_q;
  logic                   stg, start, last, free_ok;
  logic [IW-1:0]          free_idx, tgt;

  assign stg   = upd_i && !busy_q && !commit_i;
  assign start = commit_i && !busy_q;
  assign last  = (idx_q == UW'(NUM_USERS - 1));

  always_comb begin
    asg_n    = asg_q;
    inuse_n  = inuse_q;
    mode_n   = mode_q;
    free_ok  = 1'b0;
    free_idx = NONE;
    tgt      = NONE;
    for (int j = NUM_SCALERS - 1; j >= 0; j--) begin
      if (!inuse_q[j]) begin
        free_ok  = 1'b1;
        free_idx = IW'(j);
      end
    end
    if (stg && release_i) begin
      for (int j = 0; j < NUM_SCALERS; j++)
        if (asg_q[upd_user_i] == IW'(j)) inuse_n[j] = 1'b0;
      asg_n[upd_user_i] = NONE;
    end
    if (busy_q && req_q[idx_q]) begin
      tgt = asg_q[idx_q];
      if (tgt == NONE && free_ok) tgt = free_idx;
      if (tgt != NONE) begin
        if (lone_q) begin  // move the lone user onto scaler 0
          for (int j = 0; j < NUM_SCALERS; j++)
            if (tgt == IW'(j)) inuse_n[j] = 1'b0;
          tgt = '0;
        end
        for (int j = 0; j < NUM_SCALERS; j++) begin
          if (tgt == IW'(j)) begin
            inuse_n[j] = 1'b1;
            mode_n[j]  = lone_q ? MODE_HQ : SHR_MODE;
          end
        end
        asg_n[idx_q] = tgt;
      end
    end
    if (busy_q && last)
      for (int j = 0; j < NUM_SCALERS; j++)
        if (!inuse_n[j]) mode_n[j] = MODE_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= '0;
      inuse_q  <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      lone_q   <= 1'b0;
      idx_q    <= '0;
      detach_q <= '0;
      for (int u = 0; u < NUM_USERS; u++)   asg_q[u]  <= NONE;
      for (int j = 0; j < NUM_SCALERS; j++) mode_q[j] <= MODE_NORMAL;
    end else begin
      asg_q    <= asg_n;
      inuse_q  <= inuse_n;
      mode_q   <= mode_n;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      detach_q <= '0;
      if (stg) begin
        if (reject_i)       err_q <= 1'b1;
        else if (release_i) req_q[upd_user_i] <= 1'b0;
        else                req_q[upd_user_i] <= 1'b1;
      end
      if (start) begin
        if (req_cnt_i > CW'(NUM_SCALERS)) begin
          err_q  <= 1'b1;
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          lone_q <= LEGACY_MODES && (NUM_SCALERS > 1) && (req_cnt_i == CW'(1));
        end
      end else if (busy_q) begin
        if (last) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          detach_q <= ~inuse_n;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int u = 0; u < NUM_USERS; u++)   assign_o[u*IW +: IW] = asg_q[u];
    for (int j = 0; j < NUM_SCALERS; j++) mode_o[2*j +: 2]     = mode_q[j];
  end
  assign req_mask_o = req_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign detach_o   = detach_q;

  // R6
  adm_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !busy_q && req_cnt_i > CW'(NUM_SCALERS)) |=> (err_o && done_o && !busy_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && upd_i) |=> $stable(req_mask_o));
  // R9
  detach_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|detach_o) |-> done_o);
  // R2
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stg && release_i) |=> !req_mask_o[$past(upd_user_i)]);
  // R8
  lone_hq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && lone_q) |-> (mode_q[0] == MODE_HQ && inuse_q[0]));

  for (genvar j = 0; j < NUM_SCALERS; j++) begin : g_own
    logic [NUM_USERS-1:0] own;
    always_comb
      for (int u = 0; u < NUM_USERS; u++) own[u] = (asg_q[u] == IW'(j));
    // R7
    unique_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(own));
  end
endmodule

// File: rtl/scl_pool_alloc.sv
module scl_pool_alloc
  import scl_pkg::*;
#(
  parameter int NUM_USERS    = 5,
  parameter int NUM_SCALERS  = 2,
  parameter int DIM_W        = 14,
  parameter int MIN_DIM      = 8,
  parameter int MAX_DIM      = 4096,
  parameter int MIN_SEMI_DIM = 16,
  parameter bit LEGACY_MODES = 1'b1,
  localparam int UW          = $clog2(NUM_USERS),
  localparam int IW          = $clog2(NUM_SCALERS + 1),
  localparam int CW          = $clog2(NUM_USERS + 1),
  localparam int PIPE_USER   = NUM_USERS - 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      upd_i,
  input  logic [UW-1:0]             upd_user_i,
  input  logic [DIM_W-1:0]          src_w_i,
  input  logic [DIM_W-1:0]          src_h_i,
  input  logic [DIM_W-1:0]          dst_w_i,
  input  logic [DIM_W-1:0]          dst_h_i,
  input  logic                      semiplanar_i,
  input  logic                      need_i,
  input  logic                      release_i,
  input  logic                      interlaced_i,
  input  logic                      commit_i,
  output logic [NUM_USERS-1:0]      req_mask_o,
  output logic [NUM_USERS*IW-1:0]   assign_o,
  output logic [2*NUM_SCALERS-1:0]  mode_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      err_o,
  output logic [NUM_SCALERS-1:0]    detach_o
);
  timeunit 1ns; timeprecision 1ps;
  logic          is_pipe, rel, rej;
  logic [CW-1:0] req_cnt;

  assign is_pipe = (upd_user_i == UW'(PIPE_USER));

  scl_req_check #(
    .DIM_W(DIM_W), .MIN_DIM(MIN_DIM), .MAX_DIM(MAX_DIM), .MIN_SEMI_DIM(MIN_SEMI_DIM)
  ) u_chk (
    .src_w_i(src_w_i), .src_h_i(src_h_i), .dst_w_i(dst_w_i), .dst_h_i(dst_h_i),
    .semiplanar_i(semiplanar_i), .need_i(need_i), .release_i(release_i),
    .interlaced_i(interlaced_i), .is_pipe_i(is_pipe),
    .release_o(rel), .reject_o(rej)
  );

  scl_popcount #(.W(NUM_USERS), .CW(CW)) u_pc (
    .vec_i(req_mask_o), .cnt_o(req_cnt)
  );

  scl_walk #(
    .NUM_USERS(NUM_USERS), .NUM_SCALERS(NUM_SCALERS), .LEGACY_MODES(LEGACY_MODES),
    .UW(UW), .IW(IW), .CW(CW)
  ) u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_i), .upd_user_i(upd_user_i),
    .release_i(rel), .reject_i(rej), .commit_i(commit_i), .req_cnt_i(req_cnt),
    .req_mask_o(req_mask_o), .assign_o(assign_o), .mode_o(mode_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .detach_o(detach_o)
  );

  // R3
  stage_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !busy_o && !commit_i && rej) |=> (err_o && $stable(req_mask_o)));
endmodule

// File: tb/scl_pool_alloc_test.sv
module scl_pool_alloc_test;
  timeunit 1ns; timeprecision 1ps;
  localparam int NU = 5, NS = 2, DW = 14, IW = 2, UW = 3;
  localparam logic [1:0] NONE = 2'b11;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, upd, semi, need, rel, intl, commit;
  logic [UW-1:0] user;
  logic [DW-1:0] sw, sh, dw, dh;
  logic [NU-1:0] mask_w;
  logic [NU*IW-1:0] asg_w;
  logic [2*NS-1:0] mode_w;
  logic busy_w, done_w, err_w;
  logic [NS-1:0] det_w;
  int n_chk = 0, n_fail = 0;

  scl_pool_alloc uut (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .upd_user_i(user),
    .src_w_i(sw), .src_h_i(sh), .dst_w_i(dw), .dst_h_i(dh),
    .semiplanar_i(semi), .need_i(need), .release_i(rel), .interlaced_i(intl),
    .commit_i(commit), .req_mask_o(mask_w), .assign_o(asg_w), .mode_o(mode_w),
    .busy_o(busy_w), .done_o(done_w), .err_o(err_w), .detach_o(det_w)
  );

  typedef struct packed {
    logic [2:0] u;
    logic [13:0] sw, sh, dw, dh;
    logic semi, need, rel, intl, eerr;
    logic [4:0] emask;
    logic [3:0] rq;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{3'd1, 14'd100, 14'd100, 14'd200, 14'd200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00010, 4'd1}, // R1
    '{3'd0, 14'd64, 14'd64, 14'd64, 14'd64, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00010, 4'd1},     // R1
    '{3'd2, 14'd7, 14'd100, 14'd100, 14'd100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00010, 4'd3},   // R3
    '{3'd2, 14'd100, 14'd100, 14'd100, 14'd4097, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00010, 4'd3},// R3
    '{3'd2, 14'd4096, 14'd8, 14'd8, 14'd4096, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00110, 4'd3},   // R3
    '{3'd3, 14'd15, 14'd32, 14'd32, 14'd32, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00110, 4'd4},     // R4
    '{3'd3, 14'd100, 14'd100, 14'd50, 14'd50, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'b00110, 4'd5},   // R5
    '{3'd3, 14'd64, 14'd64, 14'd64, 14'd64, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00110, 4'd5},     // R5
    '{3'd4, 14'd10, 14'd10, 14'd20, 14'd20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b10110, 4'd4}      // R4
  };

  function automatic logic [1:0] asg_of(int u);
    return asg_w[u*IW +: IW];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic stage(int u, int a, int b, int c, int d, logic s, logic n, logic r, logic i);
    @(negedge clk);
    user = UW'(u); sw = DW'(a); sh = DW'(b); dw = DW'(c); dh = DW'(d);
    semi = s; need = n; rel = r; intl = i; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  int cyc; logic c_err; logic [NS-1:0] c_det; logic c_busy;
  task automatic do_commit();
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    cyc = 1; c_busy = busy_w;
    while (!done_w && cyc < 40) begin @(negedge clk); cyc++; end
    c_err = err_w; c_det = det_w;
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done_w}, 32'd0);
    chk("R9 detach one cycle", {30'd0, det_w}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; upd = 0; semi = 0; need = 0; rel = 0; intl = 0; commit = 0;
    user = '0; sw = '0; sh = '0; dw = '0; dh = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 mask", {27'd0, mask_w}, 32'd0);
    chk("R11 assign", {22'd0, asg_w}, 32'h3ff);
    chk("R11 mode", {28'd0, mode_w}, 32'd0);
    chk("R11 flags", {27'd0, busy_w, done_w, err_w, det_w}, 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < 9; k++) begin
      stage(TBL[k].u, TBL[k].sw, TBL[k].sh, TBL[k].dw, TBL[k].dh,
            TBL[k].semi, TBL[k].need, TBL[k].rel, TBL[k].intl);
      chk($sformatf("R%0d row %0d err", TBL[k].rq, k), {31'd0, err_w}, {31'd0, TBL[k].eerr});
      chk($sformatf("R%0d row %0d mask", TBL[k].rq, k), {27'd0, mask_w}, {27'd0, TBL[k].emask});
    end

    // R6 three requests on two scalers
    do_commit();
    chk("R6 reject cycle", cyc, 1);
    chk("R6 reject err", {31'd0, c_err}, 1);
    chk("R6 assign unchanged", {22'd0, asg_w}, 32'h3ff);

    // R2 forced release of the pipe user
    stage(4, 10, 10, 20, 20, 0, 0, 1, 0);
    chk("R2 mask after release", {27'd0, mask_w}, 32'b00110);

    // R6 R7 R10 count equals pool: admitted, lowest free first
    do_commit();
    chk("R10 done timing", cyc, NU + 1);
    chk("R10 busy during walk", {31'd0, c_busy}, 1);
    chk("R6 admitted no err", {31'd0, c_err}, 0);
    chk("R7 user1 scaler", asg_of(1), 0);
    chk("R7 user2 scaler", asg_of(2), 1);
    chk("R8 dynamic modes", {28'd0, mode_w}, 32'b0101);
    chk("R9 nothing detached", {30'd0, c_det}, 0);

    // R2 release by equal sizes
    stage(1, 64, 64, 64, 64, 0, 0, 0, 0);
    chk("R2 assign none", asg_of(1), NONE);
    chk("R2 mask", {27'd0, mask_w}, 32'b00100);

    // R8 R9 lone user moves to scaler 0 in HQ
    do_commit();
    chk("R8 lone on scaler0", asg_of(2), 0);
    chk("R8 hq mode", {28'd0, mode_w}, 32'b0010);
    chk("R9 detach scaler1", {30'd0, c_det}, 32'b10);

    // R7 existing kept, new user takes lowest free (1)
    stage(0, 32, 32, 64, 64, 0, 0, 0, 0);
    do_commit();
    chk("R7 new user gets scaler1", asg_of(0), 1);
    chk("R7 user2 kept scaler0", asg_of(2), 0);
    chk("R8 two users dynamic", {28'd0, mode_w}, 32'b0101);

    // R10 update while busy is ignored
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    user = 3'd3; sw = 100; sh = 100; dw = 200; dh = 200; semi = 0; need = 0; rel = 0; intl = 0;
    upd = 1'b1;
    @(negedge clk); upd = 1'b0;
    for (int w = 0; w < 40 && !done_w; w++) @(negedge clk);
    @(negedge clk);
    chk("R10 busy update ignored", {27'd0, mask_w}, 32'b00101);

    // R10 update together with commit is ignored
    @(negedge clk); commit = 1'b1; upd = 1'b1;
    @(negedge clk); commit = 1'b0; upd = 1'b0;
    for (int w = 0; w < 40 && !done_w; w++) @(negedge clk);
    @(negedge clk);
    chk("R10 update with commit ignored", {27'd0, mask_w}, 32'b00101);

    // R9 release all: every scaler detached, normal modes
    stage(0, 64, 64, 64, 64, 0, 0, 1, 0);
    stage(2, 64, 64, 64, 64, 0, 0, 1, 0);
    do_commit();
    chk("R9 detach all", {30'd0, c_det}, 32'b11);
    chk("R9 modes normal", {28'd0, mode_w}, 32'd0);
    chk("R2 all none", {22'd0, asg_w}, 32'h3ff);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule